// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in one combinational pass, producing a 16-bit sum and a carry-out. The carry is never passed from bit to bit. Each bit cell forms its own propagate (a xor b) and generate (a and b) terms. Four-bit slices group the bit cells, and each group of four has a lookahead unit. That unit works out the carries into the group's bits from flat sum-of-products terms, and it also forms a group propagate and a group generate.

A second copy of the same lookahead unit takes the four group propagate/generate pairs and the external carry-in. Its three lower carries feed groups one to three, and its top carry is the adder's carry-out. The block has no registers and no state. It sits in a datapath wherever a short, fixed-depth 16-bit add is needed.

Top module: `cla_adder16`

## Requirements
- R1: `sumOut` equals the low 16 bits of `opA + opB + carryIn` for every combination of inputs.
- R2: `carryOut` equals bit 16 of the 17-bit result of `opA + opB + carryIn`.
- R3: With both operands all ones (0xFFFF) and `carryIn` = 1, `sumOut` is 0xFFFF and `carryOut` is 1. With `carryIn` = 0 the result is 0xFFFE with `carryOut` = 1.
- R4: With both operands zero, `sumOut` equals `carryIn` (0x0000 or 0x0001) and `carryOut` is 0.
- R5: A carry-in that enters a word where every bit propagates (one operand 0xFFFF, the other 0x0000, `carryIn` = 1) passes through all four groups. The result is `sumOut` = 0x0000 and `carryOut` = 1.
- R6: A carry generated in the lowest group passes through the three upper groups when they only propagate (0xFFFF + 0x0001, `carryIn` = 0). The result is `sumOut` = 0x0000 and `carryOut` = 1.
- R7: A carry generated at the top of one 4-bit group reaches the next group (for example 0x000F + 0x0001 gives 0x0010, 0x00F0 + 0x0010 gives 0x0100, and 0x0F00 + 0x0100 gives 0x1000). The carry-out of each group's lookahead unit agrees with the carry into the next group.
- R8: Outputs depend only on the present inputs. Applying the same operands again after different ones gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
Directed vectors separate the carry paths. Zero operands show that nothing is generated. All-ones operands show that generate and propagate are both active everywhere. A pure-propagate word fed by the carry-in exercises the top lookahead unit's longest product term. Group-boundary vectors show whether each group carry is routed to the correct neighbour. A repeated vector after unrelated ones shows that the block keeps no hidden state. Ten thousand random operand pairs with random carry-in then cover the general sum and carry-out against the arithmetic result.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Result of a single bit cell.
  typedef struct packed {
    logic sumBit;
    logic propBit;
    logic genBit;
  } bitRes_t;

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
  import cla_pkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  input  logic    cBit,
  output bitRes_t res
);

  always_comb begin
    res.propBit = aBit ^ bBit;
    res.genBit  = aBit & bBit;
    res.sumBit  = res.propBit ^ cBit;
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] aIn,
  input  logic [GW-1:0] bIn,
  input  logic [GW-1:0] carryBus,
  output logic [GW-1:0] sumBits,
  output logic [GW-1:0] propBits,
  output logic [GW-1:0] genBits
);

  // Independent bit cells; no carry runs between them.
  for (genvar i = 0; i < GW; i++) begin : g_cell
    bitRes_t cellRes;
    cla_bit_cell u_cell (
      .aBit (aIn[i]),
      .bBit (bIn[i]),
      .cBit (carryBus[i]),
      .res  (cellRes)
    );
    assign sumBits[i]  = cellRes.sumBit;
    assign propBits[i] = cellRes.propBit;
    assign genBits[i]  = cellRes.genBit;
  end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] propIn,
  input  logic [N-1:0] genIn,
  input  logic         cIn,
  output logic [N-1:0] cOut,
  output logic         grpProp,
  output logic         grpGen
);

  // Each carry is a flat OR of AND terms: no carry feeds another carry.
  always_comb begin
    logic termAcc;
    logic prodTerm;
    for (int i = 0; i < N; i++) begin
      termAcc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prodTerm = genIn[j];
        for (int k = j + 1; k <= i; k++) prodTerm = prodTerm & propIn[k];
        termAcc = termAcc | prodTerm;
      end
      prodTerm = cIn;
      for (int k = 0; k <= i; k++) prodTerm = prodTerm & propIn[k];
      cOut[i] = termAcc | prodTerm;
    end
  end

  always_comb begin
    logic genAcc;
    logic genProd;
    genAcc = 1'b0;
    for (int j = 0; j < N; j++) begin
      genProd = genIn[j];
      for (int k = j + 1; k < N; k++) genProd = genProd & propIn[k];
      genAcc = genAcc | genProd;
    end
    grpGen  = genAcc;
    grpProp = &propIn;
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int WIDTH = 16,
  parameter int GW    = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int NGRP = WIDTH / GW;

  logic [NGRP-1:0]  blockP;
  logic [NGRP-1:0]  blockG;
  logic [NGRP-1:0]  groupCarry;
  logic [NGRP-1:0]  topCout;
  logic [WIDTH-1:0] groupCoutFlat;
  logic [WIDTH-1:0] propAll;
  logic [WIDTH-1:0] genAll;

  // Second level: lookahead across the groups.
  cla_lookahead #(.N(NGRP)) u_topLa (
    .propIn  (blockP),
    .genIn   (blockG),
    .cIn     (carryIn),
    .cOut    (topCout),
    .grpProp (),
    .grpGen  ()
  );

  if (NGRP > 1) begin : g_multi
    assign groupCarry = {topCout[NGRP-2:0], carryIn};
  end else begin : g_single
    assign groupCarry = carryIn;
  end
  assign carryOut = topCout[NGRP-1];

  // First level: one slice and one lookahead unit per group.
  for (genvar g = 0; g < NGRP; g++) begin : g_group
    logic [GW-1:0] carryBus;
    logic [GW-1:0] laCout;

    cla_lookahead #(.N(GW)) u_grpLa (
      .propIn  (propAll[g*GW +: GW]),
      .genIn   (genAll[g*GW +: GW]),
      .cIn     (groupCarry[g]),
      .cOut    (laCout),
      .grpProp (blockP[g]),
      .grpGen  (blockG[g])
    );

    if (GW > 1) begin : g_bus
      assign carryBus = {laCout[GW-2:0], groupCarry[g]};
    end else begin : g_bus1
      assign carryBus = groupCarry[g];
    end

    assign groupCoutFlat[g*GW +: GW] = laCout;

    cla_slice #(.GW(GW)) u_slice (
      .aIn      (opA[g*GW +: GW]),
      .bIn      (opB[g*GW +: GW]),
      .carryBus (carryBus),
      .sumBits  (sumOut[g*GW +: GW]),
      .propBits (propAll[g*GW +: GW]),
      .genBits  (genAll[g*GW +: GW])
    );
  end

endmodule

// File: rtl/cla_adder16_checker.sv
module cla_adder16_checker #(
  parameter int WIDTH = 16,
  parameter int GW    = 4
) (
  input logic [WIDTH-1:0]      opA,
  input logic [WIDTH-1:0]      opB,
  input logic                  carryIn,
  input logic [WIDTH-1:0]      sumOut,
  input logic                  carryOut,
  input logic [WIDTH/GW-1:0]   groupCarry,
  input logic [WIDTH/GW-1:0]   blockP,
  input logic [WIDTH/GW-1:0]   blockG,
  input logic [WIDTH-1:0]      groupCoutFlat
);

  localparam int NGRP = WIDTH / GW;

  always_comb begin
    logic [WIDTH:0] fullSum;
    logic [GW:0]    grpSum;
    logic           nextCarry;
    fullSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    p_sum_exact_r1: assert ({carryOut, sumOut} == fullSum)
      else $error("R1/R2 result %h expected %h", {carryOut, sumOut}, fullSum);
    for (int g = 0; g < NGRP; g++) begin
      nextCarry = (g < NGRP - 1) ? groupCarry[(g + 1) % NGRP] : carryOut;
      p_group_link_r7: assert (groupCoutFlat[g*GW + GW - 1] == nextCarry)
        else $error("R7 group %0d carry mismatch", g);
      p_block_prop_r5: assert (blockP[g] == &(opA[g*GW +: GW] ^ opB[g*GW +: GW]))
        else $error("R5 group %0d propagate mismatch", g);
      grpSum = {1'b0, opA[g*GW +: GW]} + {1'b0, opB[g*GW +: GW]};
      p_block_gen_r6: assert (blockG[g] == grpSum[GW])
        else $error("R6 group %0d generate mismatch", g);
    end
  end

endmodule

bind cla_adder16 cla_adder16_checker #(.WIDTH(WIDTH), .GW(GW)) u_chk (
  .opA           (opA),
  .opB           (opB),
  .carryIn       (carryIn),
  .sumOut        (sumOut),
  .carryOut      (carryOut),
  .groupCarry    (groupCarry),
  .blockP        (blockP),
  .blockG        (blockG),
  .groupCoutFlat (groupCoutFlat)
);

// File: tb/cla_adder16_test.sv
module cla_adder16_test;

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        ci;
    logic [16:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  item_t expQ[$];
  int    nCompared = 0;
  int    nFailed   = 0;
  bit    driveDone = 1'b0;
  int    cycleCnt  = 0;

  always #10 clk = ~clk;

  cla_adder16 uut (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input string tag);
    item_t it;
    @(posedge clk);
    opA = a;
    opB = b;
    carryIn = ci;
    it.a = a;
    it.b = b;
    it.ci = ci;
    it.exp = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares each pushed item half a cycle after it was applied.
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nCompared++;
      if ({carryOut, sumOut} !== it.exp) begin
        nFailed++;
        $display("FAIL %s: a=%h b=%h ci=%0d actual cout=%0d sum=%h expected cout=%0d sum=%h",
                 it.tag, it.a, it.b, it.ci, carryOut, sumOut, it.exp[16], it.exp[15:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      nFailed++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", cycleCnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // Reset/idle state: zero inputs give zero outputs (R4).
    drive(16'h0000, 16'h0000, 1'b0, "R4 zero cin0");
    drive(16'h0000, 16'h0000, 1'b1, "R4 zero cin1");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R3 all ones cin1");
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R3 all ones cin0");
    drive(16'hFFFF, 16'h0000, 1'b1, "R5 propagate chain");
    drive(16'h0000, 16'hFFFF, 1'b1, "R5 propagate chain swapped");
    drive(16'hFFFF, 16'h0001, 1'b0, "R6 group0 generate");
    drive(16'h000F, 16'h0001, 1'b0, "R7 boundary 0-1");
    drive(16'h00F0, 16'h0010, 1'b0, "R7 boundary 1-2");
    drive(16'h0F00, 16'h0100, 1'b0, "R7 boundary 2-3");
    drive(16'hF000, 16'h1000, 1'b0, "R2 carry out of group3");
    drive(16'h1234, 16'h4321, 1'b0, "R8 first apply");
    drive(16'h8000, 16'h7FFF, 1'b1, "R1 unrelated");
    drive(16'h1234, 16'h4321, 1'b0, "R8 repeat apply");
    for (int n = 0; n < 10000; n++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random");
    end
    driveDone = 1'b1;
    repeat (3) @(posedge clk);
    wait (expQ.size() == 0);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

endmodule